// File: doc/BRIEF.md
# Memory Request Arbiter with I/O Promotion

This block picks one memory access per cycle from a set of requesters. The requesters come in four groups: graphics engine ports, host processor ports, isochronous downstream I/O ports and upstream bus-master I/O ports. Each requester raises a request line and places an address tag beside it. The arbiter answers with a one-hot grant. The winning index and its tag go out to the downstream command queue in the same cycle.

Without promotion the order is graphics, then host, then I/O. Two rules override that order. An isochronous request always wins at once. An upstream request that has waited long enough is aged: its wait counter has reached a threshold set a safety margin below the latency ceiling. An aged upstream request then ranks above graphics and host. Inside each group, equal requests take turns by round-robin.

Top module: `mem_req_arbiter`

## Requirements
- R1: `grant` has at most one bit set. It is all zero whenever `q_ready` is low. A grant bit is set only for a requester whose `req` bit is high.
- R2: With no isochronous or aged upstream request pending, the order is graphics ports first, then host ports, then upstream ports. Index map: graphics ports are 0..N_GFX-1, followed by host, then isochronous, then upstream.
- R3: Any pending isochronous request is granted ahead of every other group while `q_ready` is high.
- R4: Within a group, the pointer starts at local index 0 after reset. The winner is the first requester at or after the pointer, wrapping round. After a grant, the pointer moves to the winner plus one.
- R5: An upstream request becomes aged once its wait counter reaches CEIL_CYC - MARGIN_CYC. An aged request is granted ahead of graphics and host, but behind isochronous requests.
- R6: An upstream wait counter clears in the cycle its request is granted. It then counts again from zero if the request stays high.
- R7: An upstream wait counter returns to zero when its request is low, and it holds there. A new request therefore waits the full threshold again.
- R8: `out_valid` is high exactly when a grant is issued. `out_src` is then the granted index, and `out_tag` is that requester's tag slice `req_tag[idx*TAG_W +: TAG_W]`.
- R9: After reset, with no request pending, `grant` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NREQ | Request lines, one per requester |
| req_tag | input | NREQ*TAG_W | Packed address tags, one slice per requester |
| q_ready | input | 1 | Downstream queue can accept a request this cycle |
| grant | output | NREQ | One-hot grant pulse |
| out_valid | output | 1 | A request is forwarded this cycle |
| out_src | output | IW | Index of the forwarded requester |
| out_tag | output | TAG_W | Tag of the forwarded requester |

## Verification
The assertions assume that a requester holds its request high until it sees its grant. The checker ages upstream requests with its own counters, so it also assumes that a request line dropping for a cycle means the old request is gone. The stimulus only changes `req` and `q_ready` at the falling edge and keeps each request steady across the waits it measures. It keeps isochronous traffic bursty enough that aged upstream requests get served, so the wait ceiling is never exceeded on purpose.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_ISO,
        WIN_AGED,
        WIN_GFX,
        WIN_HOST,
        WIN_UP
    } win_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 2,
    parameter int PW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic          any
);
    always_comb begin
        int  idx;
        logic found;
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(ptr) + i) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/arb_age_track.sv
module arb_age_track #(
    parameter int N_UP       = 2,
    parameter int CEIL_CYC   = 2500,
    parameter int MARGIN_CYC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_UP-1:0] up_req,
    input  logic [N_UP-1:0] up_gnt,
    output logic [N_UP-1:0] aged
);
    localparam int CW = $clog2(CEIL_CYC + 1);
    localparam int TH = CEIL_CYC - MARGIN_CYC;

    typedef struct packed {
        logic [N_UP-1:0][CW-1:0] cnt;
    } age_t;

    age_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_UP; i++) begin
            if (up_gnt[i] || !up_req[i])
                st_d.cnt[i] = '0;
            else if (st_q.cnt[i] != CW'(CEIL_CYC))
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
            aged[i] = up_req[i] && (int'(st_q.cnt[i]) >= TH);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
    import arb_pkg::*;
#(
    parameter int N_GFX      = 2,
    parameter int N_HOST     = 1,
    parameter int N_ISO      = 2,
    parameter int N_UP       = 2,
    parameter int TAG_W      = 8,
    parameter int CEIL_CYC   = 2500,
    parameter int MARGIN_CYC = 64,
    localparam int NREQ      = N_GFX + N_HOST + N_ISO + N_UP,
    localparam int IW        = $clog2(NREQ)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREQ-1:0]       req,
    input  logic [NREQ*TAG_W-1:0] req_tag,
    input  logic                  q_ready,
    output logic [NREQ-1:0]       grant,
    output logic                  out_valid,
    output logic [IW-1:0]         out_src,
    output logic [TAG_W-1:0]      out_tag
);
    localparam int B_HOST = N_GFX;
    localparam int B_ISO  = B_HOST + N_HOST;
    localparam int B_UP   = B_ISO + N_ISO;
    localparam int PW     = IW;

    typedef struct packed {
        logic [PW-1:0] ptr_gfx;
        logic [PW-1:0] ptr_host;
        logic [PW-1:0] ptr_iso;
        logic [PW-1:0] ptr_up;
    } arb_t;

    arb_t st_d, st_q;

    logic [N_GFX-1:0]  g_gfx;
    logic [N_HOST-1:0] g_host;
    logic [N_ISO-1:0]  g_iso;
    logic [N_UP-1:0]   g_up, g_aged, aged, up_gnt;
    logic a_gfx, a_host, a_iso, a_up, a_aged;
    win_e win;

    arb_rr_pick #(.N(N_GFX), .PW(PW)) u_gfx (
        .req(req[0 +: N_GFX]), .ptr(st_q.ptr_gfx), .gnt(g_gfx), .any(a_gfx));
    arb_rr_pick #(.N(N_HOST), .PW(PW)) u_host (
        .req(req[B_HOST +: N_HOST]), .ptr(st_q.ptr_host), .gnt(g_host), .any(a_host));
    arb_rr_pick #(.N(N_ISO), .PW(PW)) u_iso (
        .req(req[B_ISO +: N_ISO]), .ptr(st_q.ptr_iso), .gnt(g_iso), .any(a_iso));
    arb_rr_pick #(.N(N_UP), .PW(PW)) u_up (
        .req(req[B_UP +: N_UP]), .ptr(st_q.ptr_up), .gnt(g_up), .any(a_up));
    arb_rr_pick #(.N(N_UP), .PW(PW)) u_aged (
        .req(req[B_UP +: N_UP] & aged), .ptr(st_q.ptr_up), .gnt(g_aged), .any(a_aged));

    arb_age_track #(.N_UP(N_UP), .CEIL_CYC(CEIL_CYC), .MARGIN_CYC(MARGIN_CYC)) u_age (
        .clk(clk), .rst_n(rst_n), .up_req(req[B_UP +: N_UP]), .up_gnt(up_gnt), .aged(aged));

    always_comb begin
        int widx;
        st_d  = st_q;
        grant = '0;
        if (!q_ready)    win = WIN_NONE;
        else if (a_iso)  win = WIN_ISO;
        else if (a_aged) win = WIN_AGED;
        else if (a_gfx)  win = WIN_GFX;
        else if (a_host) win = WIN_HOST;
        else if (a_up)   win = WIN_UP;
        else             win = WIN_NONE;

        case (win)
            WIN_ISO:  grant[B_ISO +: N_ISO]   = g_iso;
            WIN_AGED: grant[B_UP +: N_UP]     = g_aged;
            WIN_GFX:  grant[0 +: N_GFX]       = g_gfx;
            WIN_HOST: grant[B_HOST +: N_HOST] = g_host;
            WIN_UP:   grant[B_UP +: N_UP]     = g_up;
            default:  grant = '0;
        endcase
        up_gnt = grant[B_UP +: N_UP];

        widx = 0;
        for (int i = 0; i < NREQ; i++)
            if (grant[i]) widx = i;

        out_valid = (win != WIN_NONE);
        out_src   = IW'(widx);
        out_tag   = req_tag[widx*TAG_W +: TAG_W];

        case (win)
            WIN_ISO:           st_d.ptr_iso  = PW'((widx - B_ISO + 1) % N_ISO);
            WIN_AGED, WIN_UP:  st_d.ptr_up   = PW'((widx - B_UP + 1) % N_UP);
            WIN_GFX:           st_d.ptr_gfx  = PW'((widx + 1) % N_GFX);
            WIN_HOST:          st_d.ptr_host = PW'((widx - B_HOST + 1) % N_HOST);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N_GFX      = 2,
    parameter int N_HOST     = 1,
    parameter int N_ISO      = 2,
    parameter int N_UP       = 2,
    parameter int CEIL_CYC   = 2500,
    parameter int MARGIN_CYC = 64,
    localparam int NREQ      = N_GFX + N_HOST + N_ISO + N_UP,
    localparam int IW        = $clog2(NREQ)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] req,
    input logic            q_ready,
    input logic [NREQ-1:0] grant,
    input logic            out_valid,
    input logic [IW-1:0]   out_src
);
    localparam int B_HOST = N_GFX;
    localparam int B_ISO  = B_HOST + N_HOST;
    localparam int B_UP   = B_ISO + N_ISO;
    localparam int TH     = CEIL_CYC - MARGIN_CYC;
    localparam int CW     = $clog2(CEIL_CYC + 1);

    logic [CW-1:0]   wait_c [N_UP];
    logic [N_UP-1:0] old;

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_UP; i++) begin
            if (!rst_n || !req[B_UP+i] || grant[B_UP+i]) wait_c[i] <= '0;
            else if (wait_c[i] != CW'(CEIL_CYC))         wait_c[i] <= wait_c[i] + 1'b1;
        end
    end

    always_comb
        for (int i = 0; i < N_UP; i++)
            old[i] = req[B_UP+i] && (int'(wait_c[i]) >= TH);

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !q_ready |-> (grant == '0));
    p_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    p_iso_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ready && |req[B_ISO +: N_ISO]) |-> |grant[B_ISO +: N_ISO]);
    p_aged_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ready && !(|req[B_ISO +: N_ISO]) && |old) |-> |(grant[B_UP +: N_UP] & old));
    p_gfx_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ready && !(|req[B_ISO +: N_ISO]) && !(|old) && |req[0 +: N_GFX])
        |-> |grant[0 +: N_GFX]);
    p_src_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> grant[out_src]);
endmodule

bind mem_req_arbiter arb_checker #(
    .N_GFX(N_GFX), .N_HOST(N_HOST), .N_ISO(N_ISO), .N_UP(N_UP),
    .CEIL_CYC(CEIL_CYC), .MARGIN_CYC(MARGIN_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .q_ready(q_ready),
    .grant(grant), .out_valid(out_valid), .out_src(out_src)
);

// File: tb/sim_mem_req_arbiter.sv
module sim_mem_req_arbiter;
    localparam int N  = 7;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N*TW-1:0] req_tag;
    logic          q_ready = 1'b0;
    logic [N-1:0]  grant;
    logic          out_valid;
    logic [2:0]    out_src;
    logic [TW-1:0] out_tag;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) req_tag[i*TW +: TW] = TW'(8'hA0 + i);

    mem_req_arbiter #(.N_GFX(2), .N_HOST(1), .N_ISO(2), .N_UP(2), .TAG_W(TW),
                      .CEIL_CYC(40), .MARGIN_CYC(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_tag(req_tag), .q_ready(q_ready),
        .grant(grant), .out_valid(out_valid), .out_src(out_src), .out_tag(out_tag));

    // {req[6:0], ready, expected grant[6:0]}; bits 0-1 gfx, 2 host, 3-4 iso, 5-6 upstream
    localparam logic [14:0] VEC [10] = '{
        {7'b0000011, 1'b1, 7'b0000001},  // R4 gfx port 0 first
        {7'b0000011, 1'b1, 7'b0000010},  // R4 gfx turns to port 1
        {7'b0000100, 1'b1, 7'b0000100},  // R2 host alone
        {7'b1100100, 1'b1, 7'b0000100},  // R2 host above upstream
        {7'b0011111, 1'b1, 7'b0001000},  // R3 iso over all
        {7'b0011111, 1'b1, 7'b0010000},  // R4 iso turn
        {7'b1100000, 1'b0, 7'b0000000},  // R1 not ready
        {7'b1100000, 1'b1, 7'b0100000},  // R2 upstream
        {7'b1100000, 1'b1, 7'b1000000},  // R4 upstream turn
        {7'b0000001, 1'b1, 7'b0000001}   // R2 gfx
    };

    task automatic check(input string r, input logic [N-1:0] exp);
        int idx;
        logic bad;
        idx = 0;
        for (int i = 0; i < N; i++) if (exp[i]) idx = i;
        bad = (grant !== exp) || (out_valid !== (exp != 0));
        if (exp != 0 && (out_src !== 3'(idx) || out_tag !== TW'(8'hA0 + idx))) bad = 1'b1;
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: grant=%b valid=%b src=%0d tag=%h expected grant=%b src=%0d tag=%h",
                     r, grant, out_valid, out_src, out_tag, exp, idx, 8'hA0 + idx);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R9", '0);

        for (int v = 0; v < 10; v++) begin
            @(negedge clk);
            req = VEC[v][14:8]; q_ready = VEC[v][7];
            #1; check("R1/R2/R3/R4/R8 vector", VEC[v][6:0]);
        end

        // R5 aging: gfx0 hogs, upstream 5 promoted after 32 waits; R6 cleared after grant
        @(negedge clk);
        req = 7'b0100001; q_ready = 1'b1;
        for (int k = 0; k <= 33; k++) begin
            #1; check((k == 33) ? "R6" : "R5", (k == 32) ? 7'b0100000 : 7'b0000001);
            @(negedge clk);
        end

        // R7: one idle cycle of upstream 5 resets its wait
        req = 7'b0000001;
        #1; check("R7", 7'b0000001);
        @(negedge clk);
        req = 7'b0100001;
        for (int k = 0; k <= 32; k++) begin
            #1; check("R7", (k == 32) ? 7'b0100000 : 7'b0000001);
            @(negedge clk);
        end

        // R3 iso beats aged upstream 6, then R5 aged wins at once when iso leaves
        req = 7'b1001001;
        for (int k = 0; k <= 34; k++) begin
            #1; if (k % 8 == 0 || k == 34) check("R3", 7'b0001000);
            @(negedge clk);
        end
        req = 7'b1000001;
        #1; check("R5", 7'b1000000);

        @(negedge clk);
        req = 7'b1111111; q_ready = 1'b0;
        #1; check("R1", '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected end before 200000 cycles");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule